// File: doc/BRIEF.md
# Flag Offset Register Loader

This block holds the four offset values used by the programmable flags of a dual-FIFO device: an almost-empty threshold (Y) and an almost-full threshold (X) for each of the two FIFOs. It does not compare anything itself. It only sets up the thresholds and holds them for the flag logic that sits next to it.

The loading method is chosen while master reset is held low and is kept from the moment reset is released. A low serial-mode pin selects bit-serial loading. In that mode the two flag-select pins change role: one becomes an active-low shift enable and the other becomes the serial data bit. With the serial-mode pin high, the flag-select pins pick either a parallel load, in which four writes carry the values in from the low bits of the data port, or one of three fixed thresholds that all four registers take at once.

A done output goes high once the chosen method has filled all four registers. After that, loading traffic has no further effect until the next master reset. Partial reset of either FIFO does not touch this block.

Top module: `flag_offset_loader`

## Requirements
- R1: The method is taken from `ser_mode_n` and `fsel` on every clock edge while `rst_n` is low, and the value from the last such edge stays in force after release. `ser_mode_n`=0 selects serial. With `ser_mode_n`=1, `fsel`=2'b00 selects parallel, and 2'b01, 2'b10 and 2'b11 select the presets.
- R2: The presets are 8 (`fsel`=01), 16 (`fsel`=10) and 64 (`fsel`=11). All four offset outputs take the preset during reset, and `load_done` is 1 from the first clock edge in reset onward.
- R3: In serial mode, each rising edge with `fsel[1]`=0 shifts in `fsel[0]`. The chain runs Y1, X1, Y2, X2, with each register MSB first. The first bit ends up in the MSB of `y1_ofs` and the last bit in the LSB of `x2_ofs`.
- R4: In serial mode, an edge with `fsel[1]`=1 changes no offset.
- R5: In serial mode, `load_done` rises on the edge that takes the 4×OFS_W-th bit (40 at default). Further bits change no offset until the next master reset.
- R6: In parallel mode, the edges with `wr_en`=1 load `wr_ofs` into Y1, X1, Y2 and X2 in that order. `load_done` rises with the fourth write, and later writes are ignored.
- R7: `part_rst_n` has no effect on the method, the offsets or `load_done`.
- R8: After release, changes on `ser_mode_n` and `fsel` do not change the method. Outside serial mode they change no offset.
- R9: In serial or parallel mode, all offsets read 0 and `load_done` reads 0 after a clock edge in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Master reset, active low, sampled synchronously |
| part_rst_n | input | 1 | Partial reset, active low; ignored by this block |
| ser_mode_n | input | 1 | Low selects serial loading at reset |
| fsel | input | 2 | Method/preset select in reset; in serial mode [1] is the active-low shift enable and [0] is the data bit |
| wr_en | input | 1 | Qualified data-port write, used in parallel mode |
| wr_ofs | input | OFS_W | Low bits of the data port, loaded in parallel mode |
| y1_ofs | output | OFS_W | First FIFO almost-empty offset |
| x1_ofs | output | OFS_W | First FIFO almost-full offset |
| y2_ofs | output | OFS_W | Second FIFO almost-empty offset |
| x2_ofs | output | OFS_W | Second FIFO almost-full offset |
| load_done | output | 1 | All four offsets are loaded |

## Verification
On every cycle the assertions check the following. The method does not move after release. Offsets hold once done is high and whenever the serial enable is inactive. The LSB of X2 takes the data bit on each serial shift. The load counter never passes its limit. Only the bench scenarios can show that the full 40-bit chain lands in the right registers and bit order, that done rises on exactly the last bit or the fourth write, that the preset values are correct, and that partial reset and pin changes after release leave the values intact.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
    typedef enum logic [1:0] {
        LD_SERIAL   = 2'd0,
        LD_PARALLEL = 2'd1,
        LD_PRESET   = 2'd2
    } ld_method_e;
endpackage

// File: rtl/ofs_mode_decode.sv
module ofs_mode_decode
    import ofs_pkg::*;
#(
    parameter int OFS_W = 10
) (
    input  logic             ser_mode_n,
    input  logic [1:0]       fsel,
    output ld_method_e       method,
    output logic [OFS_W-1:0] preset
);
    always_comb begin
        preset = '0;
        if (!ser_mode_n) begin
            method = LD_SERIAL;
        end else if (fsel == 2'b00) begin
            method = LD_PARALLEL;
        end else begin
            method = LD_PRESET;
            case (fsel)
                2'b01:   preset = OFS_W'(8);
                2'b10:   preset = OFS_W'(16);
                default: preset = OFS_W'(64);
            endcase
        end
    end
endmodule

// File: rtl/ofs_load_seq.sv
module ofs_load_seq #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (step && (cnt_q != limit))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign cnt  = cnt_q;
    assign done = (cnt_q == limit);

    // R5
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (clr)
        cnt_q <= limit);
endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
    import ofs_pkg::*;
#(
    parameter int OFS_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             part_rst_n,
    input  logic             ser_mode_n,
    input  logic [1:0]       fsel,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_ofs,
    output logic [OFS_W-1:0] y1_ofs,
    output logic [OFS_W-1:0] x1_ofs,
    output logic [OFS_W-1:0] y2_ofs,
    output logic [OFS_W-1:0] x2_ofs,
    output logic             load_done
);
    localparam int CHAIN_W = 4 * OFS_W;
    localparam int CNT_W   = $clog2(CHAIN_W + 1);

    typedef struct packed {
        ld_method_e       method;
        logic [OFS_W-1:0] y1;
        logic [OFS_W-1:0] x1;
        logic [OFS_W-1:0] y2;
        logic [OFS_W-1:0] x2;
    } ofs_state_t;

    ofs_state_t       st_d, st_q;
    ld_method_e       dec_method;
    logic [OFS_W-1:0] dec_preset;
    logic [CNT_W-1:0] limit, cnt;
    logic             done, step, ser_en_n, ser_bit;

    assign ser_en_n = fsel[1];
    assign ser_bit  = fsel[0];

    ofs_mode_decode #(.OFS_W(OFS_W)) u_dec (
        .ser_mode_n (ser_mode_n),
        .fsel       (fsel),
        .method     (dec_method),
        .preset     (dec_preset)
    );

    always_comb begin
        case (st_q.method)
            LD_SERIAL:   limit = CNT_W'(CHAIN_W);
            LD_PARALLEL: limit = CNT_W'(4);
            default:     limit = '0;
        endcase
    end

    always_comb begin
        step = 1'b0;
        if (rst_n && !done) begin
            if (st_q.method == LD_SERIAL)
                step = !ser_en_n;
            else if (st_q.method == LD_PARALLEL)
                step = wr_en;
        end
    end

    ofs_load_seq #(.CNT_W(CNT_W)) u_seq (
        .clk   (clk),
        .clr   (!rst_n),
        .step  (step),
        .limit (limit),
        .cnt   (cnt),
        .done  (done)
    );

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.method = dec_method;
            if (dec_method == LD_PRESET) begin
                st_d.y1 = dec_preset;
                st_d.x1 = dec_preset;
                st_d.y2 = dec_preset;
                st_d.x2 = dec_preset;
            end else begin
                st_d.y1 = '0;
                st_d.x1 = '0;
                st_d.y2 = '0;
                st_d.x2 = '0;
            end
        end else if (step) begin
            if (st_q.method == LD_SERIAL) begin
                {st_d.y1, st_d.x1, st_d.y2, st_d.x2} =
                    {st_q.y1[OFS_W-2:0], st_q.x1, st_q.y2, st_q.x2, ser_bit};
            end else begin
                case (cnt[1:0])
                    2'd0:    st_d.y1 = wr_ofs;
                    2'd1:    st_d.x1 = wr_ofs;
                    2'd2:    st_d.y2 = wr_ofs;
                    default: st_d.x2 = wr_ofs;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign y1_ofs    = st_q.y1;
    assign x1_ofs    = st_q.x1;
    assign y2_ofs    = st_q.y2;
    assign x2_ofs    = st_q.x2;
    assign load_done = done;

    initial begin
        // R2
        width_fits_preset_chk: assert (OFS_W >= 8);
    end

    // R8
    method_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(st_q.method));

    // R5
    hold_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> (load_done && $stable({y1_ofs, x1_ofs, y2_ofs, x2_ofs})));

    // R4
    serial_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.method == LD_SERIAL && ser_en_n) |=>
            $stable({y1_ofs, x1_ofs, y2_ofs, x2_ofs}));

    // R3
    serial_bit_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.method == LD_SERIAL && !load_done && !ser_en_n) |=>
            (x2_ofs[0] == $past(ser_bit)));

    // R7
    partial_reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!part_rst_n && load_done) |=> $stable({y1_ofs, x1_ofs, y2_ofs, x2_ofs}));
endmodule

// File: tb/sim_flag_offset_loader.sv
module sim_flag_offset_loader;
    localparam int W = 10;
    localparam int CW = 4 * W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         part_rst_n = 1'b1;
    logic         ser_mode_n = 1'b1;
    logic [1:0]   fsel = 2'b00;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_ofs = '0;
    logic [W-1:0] y1_ofs, x1_ofs, y2_ofs, x2_ofs;
    logic         load_done;

    int vectors = 0;
    int miscompares = 0;

    flag_offset_loader #(.OFS_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .part_rst_n(part_rst_n),
        .ser_mode_n(ser_mode_n), .fsel(fsel), .wr_en(wr_en), .wr_ofs(wr_ofs),
        .y1_ofs(y1_ofs), .x1_ofs(x1_ofs), .y2_ofs(y2_ofs), .x2_ofs(x2_ofs),
        .load_done(load_done)
    );

    always #4ns clk = ~clk;

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [63:0] all_ofs();
        return {24'd0, y1_ofs, x1_ofs, y2_ofs, x2_ofs};
    endfunction

    function automatic logic [63:0] pack4(input logic [W-1:0] a, input logic [W-1:0] b,
                                          input logic [W-1:0] c, input logic [W-1:0] d);
        return {24'd0, a, b, c, d};
    endfunction

    // Drive at negedge, hold reset low for four edges, release at a negedge.
    task automatic master_reset(input logic mode_n, input logic [1:0] sel);
        @(negedge clk);
        rst_n = 1'b0; ser_mode_n = mode_n; fsel = sel; wr_en = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        fsel = 2'b10;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0; ser_mode_n = 1'b0; fsel = 2'b11;
        repeat (2) @(negedge clk);
        chk("R9 serial offsets in reset", all_ofs(), 64'd0);
        chk("R9 serial done in reset", {63'd0, load_done}, 64'd0);
        ser_mode_n = 1'b1; fsel = 2'b00;
        @(negedge clk);
        chk("R9 parallel offsets in reset", all_ofs(), 64'd0);
        chk("R9 parallel done in reset", {63'd0, load_done}, 64'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_presets();
        logic [W-1:0] pv [3] = '{W'(8), W'(16), W'(64)};
        for (int i = 0; i < 3; i++) begin
            master_reset(1'b1, 2'(i + 1));
            chk("R2 preset offsets", all_ofs(), pack4(pv[i], pv[i], pv[i], pv[i]));
            chk("R2 preset done", {63'd0, load_done}, 64'd1);
        end
        // R8: pin changes after release
        ser_mode_n = 1'b0; fsel = 2'b00;
        repeat (3) @(negedge clk);
        fsel = 2'b01;
        @(negedge clk);
        chk("R8 preset held after pin change", all_ofs(), pack4(W'(64), W'(64), W'(64), W'(64)));
        // R7: partial reset pulse
        part_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        part_rst_n = 1'b1;
        @(negedge clk);
        chk("R7 partial reset keeps offsets", all_ofs(), pack4(W'(64), W'(64), W'(64), W'(64)));
        chk("R7 partial reset keeps done", {63'd0, load_done}, 64'd1);
        ser_mode_n = 1'b1;
    endtask

    task automatic t_serial();
        logic [CW-1:0] chain = 40'hA5_3C_96_E1_7B;
        master_reset(1'b0, 2'b11);
        chk("R9 serial start zero", all_ofs(), 64'd0);
        for (int i = 0; i < CW; i++) begin
            fsel = {1'b0, chain[CW-1-i]};
            @(negedge clk);
            if (i == 14) begin
                logic [63:0] snap = all_ofs();
                fsel = 2'b11;
                repeat (3) @(negedge clk);
                chk("R4 serial enable high holds", all_ofs(), snap);
            end
            if (i == CW - 2)
                chk("R5 done low before last bit", {63'd0, load_done}, 64'd0);
        end
        fsel = 2'b10;
        chk("R5 done after last bit", {63'd0, load_done}, 64'd1);
        chk("R3 chain order", all_ofs(),
            pack4(chain[4*W-1:3*W], chain[3*W-1:2*W], chain[2*W-1:W], chain[W-1:0]));
        for (int i = 0; i < 5; i++) begin
            fsel = {1'b0, i[0]};
            @(negedge clk);
        end
        fsel = 2'b10;
        chk("R5 extra bits ignored", all_ofs(),
            pack4(chain[4*W-1:3*W], chain[3*W-1:2*W], chain[2*W-1:W], chain[W-1:0]));
        part_rst_n = 1'b0;
        @(negedge clk);
        part_rst_n = 1'b1;
        @(negedge clk);
        chk("R7 serial values after partial reset", all_ofs(),
            pack4(chain[4*W-1:3*W], chain[3*W-1:2*W], chain[2*W-1:W], chain[W-1:0]));
    endtask

    task automatic t_parallel();
        logic [W-1:0] v [4] = '{W'(10'h123), W'(10'h2F0), W'(10'h00A), W'(10'h3FF)};
        master_reset(1'b1, 2'b00);
        chk("R1 parallel not done after release", {63'd0, load_done}, 64'd0);
        for (int i = 0; i < 4; i++) begin
            wr_en = 1'b1; wr_ofs = v[i];
            @(negedge clk);
            wr_en = 1'b0; wr_ofs = ~v[i];
            fsel = 2'(i);
            @(negedge clk);
            if (i == 1)
                chk("R6 partial parallel load", all_ofs(), pack4(v[0], v[1], '0, '0));
            if (i == 2)
                chk("R6 done low after three writes", {63'd0, load_done}, 64'd0);
        end
        chk("R6 parallel order", all_ofs(), pack4(v[0], v[1], v[2], v[3]));
        chk("R6 done after four writes", {63'd0, load_done}, 64'd1);
        wr_en = 1'b1; wr_ofs = W'(10'h155);
        @(negedge clk);
        wr_en = 1'b0;
        ser_mode_n = 1'b0; fsel = 2'b01;
        repeat (2) @(negedge clk);
        chk("R8 extra write and pin change ignored", all_ofs(), pack4(v[0], v[1], v[2], v[3]));
        ser_mode_n = 1'b1;
    endtask

    initial begin
        fork
            begin
                t_reset_state();
                t_presets();
                t_serial();
                t_parallel();
            end
            begin
                repeat (20000) @(posedge clk);
                vectors++; miscompares++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule